// File: doc/BRIEF.md
# Vertical Format Channel Stepper

This block moves paper under the control of a vertical format table. The table lives in an external RAM of 12-bit words, one word per line of the form; bit `c` of a word marks that line as a stop for channel `c`, and channel 0 marks the top of form. The block keeps a line pointer into the table, which wraps to 0 at the current format length. It also keeps a 12-bit page counter that is decremented each time paper comes to rest on a top-of-form line.

Two commands are accepted. An advance command feeds a given number of lines and moves the pointer with them. A slew command searches forward around the form for the next line that stops on the requested channel. The block reports each line feed and form feed as a one-cycle strobe and tells the column logic to clear its count. It ends every command with a one-cycle `done` pulse carrying a continue or stop result. Stop is reported when the page counter runs out, when the format table is unusable, or when a slew finds no matching line.

Top module: `vfs_stepper`

## Requirements
- R1: After reset the pointer and page counter are 0, `busy`, all strobes, `done`, `page_zero` and `fmt_err` are low.
- R2: An advance command with argument N>0 gives exactly N `nl_strobe` pulses, one per cycle, and moves the pointer forward N lines modulo `fmt_len`. `col_clear` is high in exactly the cycles where `nl_strobe` or `ff_strobe` is high. With N=0 the command ends at once with continue and emits nothing.
- R3: After the lines of an advance, if bit 0 of the word at the pointer is set, the page counter is decremented modulo 4096. If the new count is 0, `page_zero` is set and the result is stop; otherwise `page_zero` is cleared and the result is continue. If bit 0 is clear, the result is continue and the counter and `page_zero` are left unchanged.
- R4: A slew command selects the channel given by its argument. An argument above 11 selects channel 7. The search steps the pointer forward one line per cycle, with wrap, and tests bit `channel` of each word it lands on.
- R5: When a slew on a nonzero channel lands on a matching line after i+1 steps, it emits i+1 `nl_strobe` pulses. The pointer stays on the matching line, and the top-of-form check of R3 then applies.
- R6: When a slew on channel 0 lands on a matching line, it emits one `nl_strobe` first if `col_nonzero` is high. It then emits `ff_strobe` in the same cycle as `done`, and decrements the page counter with the zero and result rules of R3.
- R7: When a slew completes one full pass of `fmt_len` steps without a match, `fmt_err` is set and the result is stop. No strobe is emitted, and the pointer ends where it started.
- R8: A command issued while `fmt_len` is 0 or `fmt_err` is set ends in the next cycle with stop. It sets `fmt_err` and changes neither the pointer nor the page counter.
- R9: While `busy` is high, `cmd_valid`, `fmt_reload` and `page_load` have no effect on the outcome of the running command.
- R10: In the idle state, `fmt_reload` clears `fmt_err` and returns the pointer to line 0, and `page_load` loads the page counter from `page_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_slew | input | 1 | 1 = slew to channel, 0 = advance lines |
| cmd_arg | input | 4 | Line count or channel number |
| fmt_len | input | 8 | Number of lines in the format table |
| fmt_reload | input | 1 | New table loaded: clear error, pointer to 0 |
| page_load | input | 1 | Load the page counter |
| page_value | input | 12 | Page counter load value |
| col_nonzero | input | 1 | Column counter is not at column 0 |
| ram_addr | output | 8 | Format table read address |
| ram_data | input | 12 | Format table word at `ram_addr` (combinational read) |
| line_ptr | output | 8 | Current line pointer |
| page_left | output | 12 | Current page count |
| busy | output | 1 | A command is running |
| nl_strobe | output | 1 | One line feed |
| ff_strobe | output | 1 | One form feed |
| col_clear | output | 1 | Reset the column counter |
| done | output | 1 | Command finished |
| cont | output | 1 | Result with `done`: 1 continue, 0 stop |
| page_zero | output | 1 | Page counter reached zero |
| fmt_err | output | 1 | Format table unusable |

## Verification
On a channel-0 slew, the form feed, the page decrement, the possible page-zero stop and the `done` pulse all fall in one cycle. A line feed for a dirty column must come out in the cycle before them. The bench provokes this collision by slewing to top of form from every pointer position, with `col_nonzero` both high and low and with the page counter loaded to 1 or 2. Each time it checks that `ff_strobe` is seen only together with `done`, that no line feed follows it, and that `cont`, `page_zero` and `page_left` match the arithmetic count kept in the bench.

// File: rtl/vfs_pkg.sv
// Package: shared state encoding for the vertical format stepper.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package vfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a command
        ST_LINES = 3'd1,   // emitting line feeds
        ST_TOF   = 3'd2,   // top-of-form test after feeding lines
        ST_SEEK  = 3'd3,   // circular channel search
        ST_FORM  = 3'd4    // form feed and page count
    } vfs_state_t;
endpackage

// File: rtl/vfs_ptr_step.sv
// Module: computes the line that follows a pointer in a form of given length.
// Assumes len > 0 when the result is used; a pointer at or past len wraps to 0.
module vfs_ptr_step #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] ptr,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] nxt
);
    logic [LEN_W:0] inc;

    // Purpose: increment with wrap at the form length.
    always_comb begin
        inc = {1'b0, ptr} + 1'b1;
        if (inc >= {1'b0, len}) nxt = '0;
        else                    nxt = inc[LEN_W-1:0];
    end
endmodule

// File: rtl/vfs_page_ctr.sv
// Module: page counter, loadable, counts down modulo 2**PG_W.
// Assumes load and dec are never requested together (load wins if they are).
module vfs_page_ctr #(
    parameter int PG_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PG_W-1:0] load_val,
    input  logic            dec,
    output logic [PG_W-1:0] count,
    output logic            zero_after
);
    // Purpose: flag that the next decrement lands on zero.
    assign zero_after = (count == PG_W'(1));

    // Purpose: hold, load or decrement the page count.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (dec)  count <= count - 1'b1;
    end

    // The count only moves when a load or a decrement was requested (R3, R10).
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(count));
endmodule

// File: rtl/vfs_stepper.sv
// Module: vertical format channel stepper (top).
// Drives line feeds and form feeds from a format table read through ram_addr /
// ram_data; ram_data must be a combinational read of the word at ram_addr.
// One pointer step or one line feed per clock; commands are taken only while idle.
module vfs_stepper #(
    parameter int LEN_W       = 8,
    parameter int CHANS       = 12,
    parameter int PG_W        = 12,
    parameter int ARG_W       = 4,
    parameter int FALLBACK_CH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_slew,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic [LEN_W-1:0] fmt_len,
    input  logic             fmt_reload,
    input  logic             page_load,
    input  logic [PG_W-1:0]  page_value,
    input  logic             col_nonzero,
    output logic [LEN_W-1:0] ram_addr,
    input  logic [CHANS-1:0] ram_data,
    output logic [LEN_W-1:0] line_ptr,
    output logic [PG_W-1:0]  page_left,
    output logic             busy,
    output logic             nl_strobe,
    output logic             ff_strobe,
    output logic             col_clear,
    output logic             done,
    output logic             cont,
    output logic             page_zero,
    output logic             fmt_err
);
    import vfs_pkg::*;

    localparam int MAX_CH = CHANS - 1;
    localparam int CNT_W  = LEN_W + 1;

    vfs_state_t       state;
    logic [LEN_W-1:0] ptr, ptr_nxt, steps;
    logic [CNT_W-1:0] lines_left;
    logic             move_ptr;
    logic [ARG_W-1:0] chan, chan_req;
    logic             hit, pg_dec, pg_load, pg_zero_after;

    // Purpose: map an out-of-range channel request onto the fallback channel.
    assign chan_req = (int'(cmd_arg) > MAX_CH) ? ARG_W'(FALLBACK_CH) : cmd_arg;

    vfs_ptr_step #(.LEN_W(LEN_W)) u_step (
        .ptr (ptr),
        .len (fmt_len),
        .nxt (ptr_nxt)
    );

    // Purpose: search reads the next line, all other states read the current one.
    assign ram_addr = (state == ST_SEEK) ? ptr_nxt : ptr;
    assign hit      = ram_data[chan];

    assign pg_load = page_load && (state == ST_IDLE);
    assign pg_dec  = ((state == ST_TOF) && ram_data[0]) || (state == ST_FORM);

    vfs_page_ctr #(.PG_W(PG_W)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pg_load),
        .load_val   (page_value),
        .dec        (pg_dec),
        .count      (page_left),
        .zero_after (pg_zero_after)
    );

    assign line_ptr  = ptr;
    assign busy      = (state != ST_IDLE);
    assign col_clear = nl_strobe | ff_strobe;

    // Purpose: command sequencing, pointer motion and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            steps      <= '0;
            lines_left <= '0;
            move_ptr   <= 1'b0;
            chan       <= '0;
            nl_strobe  <= 1'b0;
            ff_strobe  <= 1'b0;
            done       <= 1'b0;
            cont       <= 1'b0;
            page_zero  <= 1'b0;
            fmt_err    <= 1'b0;
        end else begin
            nl_strobe <= 1'b0;
            ff_strobe <= 1'b0;
            done      <= 1'b0;
            cont      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fmt_reload) begin
                        ptr     <= '0;
                        fmt_err <= 1'b0;
                    end else if (cmd_valid) begin
                        if (fmt_len == '0 || fmt_err) begin
                            fmt_err <= 1'b1;
                            done    <= 1'b1;
                        end else if (!cmd_slew) begin
                            if (cmd_arg == '0) begin
                                done <= 1'b1;
                                cont <= 1'b1;
                            end else begin
                                lines_left <= CNT_W'(cmd_arg);
                                move_ptr   <= 1'b1;
                                state      <= ST_LINES;
                            end
                        end else begin
                            chan  <= chan_req;
                            steps <= '0;
                            state <= ST_SEEK;
                        end
                    end
                end
                ST_LINES: begin
                    nl_strobe  <= 1'b1;
                    lines_left <= lines_left - 1'b1;
                    if (move_ptr) ptr <= ptr_nxt;
                    if (lines_left == CNT_W'(1)) state <= ST_TOF;
                end
                ST_TOF: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (ram_data[0]) begin
                        cont      <= !pg_zero_after;
                        page_zero <= pg_zero_after;
                    end else begin
                        cont <= 1'b1;
                    end
                end
                ST_SEEK: begin
                    ptr <= ptr_nxt;
                    if (hit) begin
                        if (chan != '0) begin
                            lines_left <= {1'b0, steps} + 1'b1;
                            move_ptr   <= 1'b0;
                            state      <= ST_LINES;
                        end else begin
                            nl_strobe <= col_nonzero;
                            state     <= ST_FORM;
                        end
                    end else if (steps == fmt_len - 1'b1) begin
                        fmt_err <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        steps <= steps + 1'b1;
                    end
                end
                ST_FORM: begin
                    ff_strobe <= 1'b1;
                    done      <= 1'b1;
                    cont      <= !pg_zero_after;
                    page_zero <= pg_zero_after;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A form feed always closes its command and never shares a cycle with a line feed.
    assert_ff_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ff_strobe |-> (done && !nl_strobe));

    // Line feeds only come out of a running command.
    assert_nl_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nl_strobe |-> busy);

    // A format error is raised only as a stop result.
    assert_err_is_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> (done && !cont));

    // Running out of pages is reported as a stop.
    assert_page_zero_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_zero) |-> (done && !cont));

    // Completion is reported with the block back in idle.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sim_vfs_stepper.sv
module sim_vfs_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_slew = 1'b0;
    logic [3:0]  cmd_arg = '0;
    logic [7:0]  fmt_len = '0;
    logic        fmt_reload = 1'b0, page_load = 1'b0, col_nonzero = 1'b0;
    logic [11:0] page_value = '0;
    logic [7:0]  ram_addr, line_ptr;
    logic [11:0] ram_data, page_left;
    logic        busy, nl_strobe, ff_strobe, col_clear, done, cont, page_zero, fmt_err;

    logic [11:0] mem [256];
    assign ram_data = mem[ram_addr];

    int n_cmp = 0, n_bad = 0;
    // reference state
    int ep = 0, epg = 0;
    bit epz = 0, eerr = 0;

    always #2.5 clk = ~clk;

    vfs_stepper u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_slew(cmd_slew),
        .cmd_arg(cmd_arg), .fmt_len(fmt_len), .fmt_reload(fmt_reload),
        .page_load(page_load), .page_value(page_value), .col_nonzero(col_nonzero),
        .ram_addr(ram_addr), .ram_data(ram_data), .line_ptr(line_ptr),
        .page_left(page_left), .busy(busy), .nl_strobe(nl_strobe),
        .ff_strobe(ff_strobe), .col_clear(col_clear), .done(done), .cont(cont),
        .page_zero(page_zero), .fmt_err(fmt_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // top-of-form test shared by R3/R5/R6
    function automatic bit ref_tof_dec();
        epg = (epg - 1) & 12'hFFF;
        epz = (epg == 0);
        return !epz;
    endfunction

    // reference model of one command, straight from the requirements
    task automatic ref_cmd(input bit slew, input int arg, input bit colnz,
                           output int enl, output int eff, output bit econt);
        int len = int'(fmt_len);
        enl = 0; eff = 0; econt = 0;
        if (len == 0 || eerr) begin
            eerr = 1; return;                      // R8
        end
        if (!slew) begin                           // R2, R3
            if (arg == 0) begin econt = 1; return; end
            enl = arg;
            ep = (ep + arg) % len;
            econt = mem[ep][0] ? ref_tof_dec() : 1'b1;
        end else begin                             // R4..R7
            int c = (arg > 11) ? 7 : arg;
            for (int i = 0; i < len; i++) begin
                ep = (ep + 1) % len;
                if (mem[ep][c]) begin
                    if (c != 0) begin
                        enl = i + 1;
                        econt = mem[ep][0] ? ref_tof_dec() : 1'b1;
                    end else begin
                        enl = colnz ? 1 : 0;
                        eff = 1;
                        econt = ref_tof_dec();
                    end
                    return;
                end
            end
            eerr = 1;                              // R7: full pass, ep back at start
        end
    endtask

    task automatic run(input bit slew, input int arg, input bit colnz,
                       input bit inject, input string req);
        int enl, eff, gnl = 0, gff = 0, it = 0;
        bit econt, got = 0, order_bad = 0, gcont = 0;
        ref_cmd(slew, arg, colnz, enl, eff, econt);
        cmd_valid = 1; cmd_slew = slew; cmd_arg = 4'(arg); col_nonzero = colnz;
        @(negedge clk);
        cmd_valid = 0;
        while (!got && it < 2000) begin
            if (inject && it == 2) begin               // R9: disturb a busy block
                cmd_valid = 1; cmd_slew = 0; cmd_arg = 4'd5;
                fmt_reload = 1; page_load = 1; page_value = 12'd77;
            end
            if (inject && it == 3) begin
                cmd_valid = 0; fmt_reload = 0; page_load = 0;
            end
            if (col_clear != (nl_strobe | ff_strobe)) order_bad = 1;   // R2
            if (ff_strobe) begin
                gff++;
                if (!done) order_bad = 1;                              // R6
            end
            if (nl_strobe) begin
                gnl++;
                if (gff != 0) order_bad = 1;
            end
            if (done) begin got = 1; gcont = cont; end
            else begin @(negedge clk); it++; end
        end
        cmd_valid = 0; fmt_reload = 0; page_load = 0;
        if (!got) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: watchdog, actual no done expected done", req);
            return;
        end
        chk({req, " newlines"}, gnl, enl);
        chk({req, " formfeeds"}, gff, eff);
        chk({req, " ordering"}, int'(order_bad), 0);
        chk({req, " result"}, int'(gcont), int'(econt));
        chk({req, " pointer"}, int'(line_ptr), ep);
        chk({req, " pages"}, int'(page_left), epg);
        chk({req, " page_zero"}, int'(page_zero), int'(epz));
        chk({req, " fmt_err"}, int'(fmt_err), int'(eerr));
        @(negedge clk);
        chk({req, " busy after done"}, int'(busy), 0);
    endtask

    task automatic load_pages(input int v);
        page_load = 1; page_value = 12'(v);
        @(negedge clk); page_load = 0;
        epg = v;
        chk("R10 page load", int'(page_left), v);
    endtask

    task automatic reload();
        fmt_reload = 1;
        @(negedge clk); fmt_reload = 0;
        ep = 0; eerr = 0;
        chk("R10 reload ptr", int'(line_ptr), 0);
        chk("R10 reload err", int'(fmt_err), 0);
    endtask

    // global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // table: bit0 at line 0; channel c=1..8 at lines with i%(c+2)==1; 9..11 empty
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            if (i == 0) mem[i][0] = 1'b1;
            for (int c = 1; c <= 8; c++)
                if (i % (c + 2) == 1) mem[i][c] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ptr", int'(line_ptr), 0);
        chk("R1 pages", int'(page_left), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 strobes", int'(nl_strobe | ff_strobe | col_clear | done), 0);
        chk("R1 flags", int'(page_zero | fmt_err), 0);

        // R8: zero length
        fmt_len = 8'd0;
        run(0, 3, 0, 0, "R8 zero length");
        run(1, 2, 0, 0, "R8 error held");
        fmt_len = 8'd12;
        run(0, 1, 0, 0, "R8 sticky error");
        reload();

        // R2/R3: every advance count, page counter passing through zero
        load_pages(2);
        for (int n = 0; n < 16; n++) run(0, n, n[0], 0, "R2 advance");
        load_pages(1);
        for (int n = 0; n < 16; n++) run(0, n, 0, 0, "R3 advance tof");

        // R4/R5/R6/R7: every channel request from many start lines
        for (int rnd = 0; rnd < 12; rnd++) begin
            load_pages(rnd % 3 + 1);
            for (int c = 0; c < 16; c++) begin
                if (eerr) reload();
                run(1, c, (rnd + c) % 2 == 1, 0, "R5 slew");
            end
            run(0, 1, 0, 0, "R2 step");
        end

        // R6: channel 0 from every pointer, dirty and clean column
        for (int s = 0; s < 12; s++) begin
            load_pages(s % 2 + 1);
            reload();
            if (s != 0) run(0, s, 0, 0, "R2 position");
            run(1, 0, s[0], 0, "R6 top of form");
        end

        // R7 then R8: empty channel, then command while in error
        reload();
        run(0, 5, 0, 0, "R2 position");
        run(1, 10, 0, 0, "R7 no stop");
        run(0, 2, 0, 0, "R8 after err");
        reload();
        run(1, 14, 0, 0, "R4 fallback");

        // R9: command, reload and page load while busy
        load_pages(40);
        run(0, 15, 1, 1, "R9 busy advance");
        run(1, 1, 0, 1, "R9 busy slew");

        // R7 on a short form
        fmt_len = 8'd1;
        reload();
        run(1, 3, 0, 0, "R7 short form");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule